// File: doc/BRIEF.md
# Command Stream Prefetch Front End

This block sits between memory and a single in-order command decoder. Host software writes a word count and then a start address into two host-visible registers. The address write starts a new stream. The block then issues burst read requests on a request/response memory port that may take many cycles to answer. It keeps reading ahead for as long as its FIFO has room, so that the long memory latency stays hidden from the decoder. The decoder receives the words strictly in address order over a valid/ready pair.

The decoder can redirect the stream. A jump moves the fetch point to a new address with a new word count. A call does the same and also saves the point where the current stream resumes. A return goes back to the most recently saved point. Each redirect discards the buffered words and moves the block to a new epoch. Responses that carry an older epoch tag are then dropped as they arrive.

The most significant address bit selects the target memory: local memory or host-mapped memory reached over the bus. An idle flag reports that the whole programmed stream has been handed to the decoder. A sticky error flag records misuse of the return stack.

Top module: `cmd_prefetch`

## Requirements
- R1: After reset, `idle` is 1, while `cmd_valid`, `rd_req_valid` and `seq_err` are 0.
- R2: A host write with `host_sel`=0 sets the word count. A host write with `host_sel`=1 sets the start address and starts a stream. The decoder then receives exactly the words at the start address, start+1, … start+count-1, in that order. Each word is the memory data returned for its address.
- R3: A new request is issued only while (FIFO capacity − FIFO occupancy − words requested but not yet returned) ≥ BURST. With the decoder stalled, at most FIFO_DEPTH words are requested beyond the words already consumed.
- R4: Each request asks for min(BURST, words still to fetch) words. The next request address follows on from the previous request, so the final request of a stream may be short.
- R5: `rd_req_host` equals bit ADDR_W-1 of `rd_req_addr`, where 1 selects host-mapped memory.
- R6: A redirect flushes the FIFO. The next word delivered is the word at the redirect target, and no response for the old stream reaches the decoder.
- R7: `redir_kind` codes are 0 jump, 1 call, 2 return, and 3 is treated as jump. A call saves the next undelivered word address and its remaining count, then jumps. A return resumes the stream from the most recently saved point.
- R8: The return stack holds STACK_DEPTH points and is last-in first-out. A call when the stack is full sets `seq_err`, saves nothing, and still jumps.
- R9: A return with an empty stack sets `seq_err` and ends the stream: `idle` rises and no further word is delivered.
- R10: `seq_err` stays set until the next start-address write, which clears it and empties the return stack.
- R11: `idle` is 1 exactly when every programmed word of the current stream has been accepted by the decoder. While it is 1, neither `cmd_valid` nor `rd_req_valid` is asserted.
- R12: `rd_req_tag` carries the current epoch. The epoch advances by one, modulo 2^EPOCH_W, on each start write and each redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 1 | 0 selects the word count register, 1 selects the start address register (the write starts a stream) |
| host_wdata | input | ADDR_W | Host write data |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | ADDR_W | Word address of the first word of the burst |
| rd_req_len | output | $clog2(BURST+1) | Words in the burst |
| rd_req_tag | output | EPOCH_W | Epoch tag, echoed on every response beat |
| rd_req_host | output | 1 | Target select: 1 means host-mapped memory |
| rsp_valid | input | 1 | Response beat valid (beats come in request order) |
| rsp_tag | input | EPOCH_W | Tag of the request this beat answers |
| rsp_data | input | DATA_W | Response word |
| cmd_valid | output | 1 | Command word available to the decoder |
| cmd_ready | input | 1 | Decoder takes the word |
| cmd_data | output | DATA_W | Command word |
| redir_valid | input | 1 | Decoder redirect strobe |
| redir_kind | input | 2 | 0 jump, 1 call, 2 return, 3 jump |
| redir_addr | input | ADDR_W | Jump or call target address |
| redir_len | input | LEN_W | Jump or call target word count |
| idle | output | 1 | All programmed words have been consumed |
| seq_err | output | 1 | Sticky return-stack overflow or underflow |

## Verification
The bench builds the block with its default parameters: a 16-word FIFO, 4-word bursts, a 4-entry return stack and a 2-bit epoch. With a memory latency of 20 cycles and a stalled decoder, the FIFO fills completely, which exposes the read-ahead bound and shows whether any request is issued beyond the free space. The 4-entry stack overflows on the fifth nested call, and a 12-cycle latency leaves reads in flight when a jump arrives, so stale responses must be dropped. A 10-word stream makes the last burst short, and a start address with the top bit set exercises the memory select.

// File: rtl/cbf_pkg.sv
// Shared definitions for the command stream prefetch front end.
// Assumes: redirect codes are fixed by the decoder that drives them.
package cbf_pkg;
    typedef enum logic [1:0] {
        REDIR_JUMP   = 2'd0,
        REDIR_CALL   = 2'd1,
        REDIR_RETURN = 2'd2,
        REDIR_JUMP_X = 2'd3
    } redir_kind_e;

    localparam logic HOST_SEL_COUNT = 1'b0;
    localparam logic HOST_SEL_START = 1'b1;
endpackage

// File: rtl/cbf_fifo.sv
// Prefetch FIFO between the response path and the command decoder.
// Assumes: the writer never writes when full (the credit check prevents it),
// and rd_en is only asserted when not empty. Flush empties it in one cycle.
module cbf_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic [CNT_W-1:0]  count
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (wr_en && !flush) mem[wr_ptr] <= wr_data;
    end

    // Pointer and occupancy bookkeeping with flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({wr_en, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign rd_data = mem[rd_ptr];
    assign empty   = (count == '0);

    // R3: the credit scheme must keep writes within capacity.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && !flush) |-> (count < CNT_W'(DEPTH)));

    // R2: the decoder never takes a word from an empty FIFO.
    p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !flush) |-> !empty);
endmodule

// File: rtl/cbf_ret_stack.sv
// Return-point stack for call/return redirects.
// Assumes: push and pop are never asserted together. A push when full and a
// pop when empty are ignored here; the parent flags them as errors.
module cbf_ret_stack #(
    parameter int ENT_W = 32,
    parameter int DEPTH = 4,
    localparam int SP_W  = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic             pop,
    input  logic [ENT_W-1:0] push_data,
    output logic [ENT_W-1:0] top_data,
    output logic             full,
    output logic             empty
);
    logic [ENT_W-1:0] ent [DEPTH];
    logic [SP_W-1:0]  sp;
    logic [IDX_W-1:0] top_idx;

    // One storage slot per level; a slot loads when a push lands on it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && !full && sp == SP_W'(g)) ent[g] <= push_data;
        end
    end

    // Stack pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)     sp <= '0;
        else if (push && !full)  sp <= sp + 1'b1;
        else if (pop && !empty)  sp <= sp - 1'b1;
    end

    assign full     = (sp == SP_W'(DEPTH));
    assign empty    = (sp == '0);
    assign top_idx  = IDX_W'(sp - 1'b1);
    assign top_data = empty ? '0 : ent[top_idx];

    // R8: a push on a full stack leaves the depth unchanged.
    p_full_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !clear) |=> (sp == $past(sp)));

    // R8: depth never exceeds capacity.
    p_depth_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sp <= SP_W'(DEPTH));
endmodule

// File: rtl/cbf_req_gen.sv
// Fetch-address walker and burst request issuer with read-ahead credit.
// Assumes: memory answers each request with req_len beats in request order,
// and the parent only reports beats of the current epoch via beat_take.
module cbf_req_gen #(
    parameter int ADDR_W  = 16,
    parameter int LEN_W   = 16,
    parameter int DEPTH   = 16,
    parameter int BURST   = 4,
    parameter int EPOCH_W = 2,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int BL_W   = $clog2(BURST + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [ADDR_W-1:0]  load_addr,
    input  logic [LEN_W-1:0]   load_len,
    input  logic [CNT_W-1:0]   fifo_count,
    input  logic               beat_take,
    input  logic               req_ready,
    output logic               req_valid,
    output logic [ADDR_W-1:0]  req_addr,
    output logic [BL_W-1:0]    req_len,
    output logic [EPOCH_W-1:0] req_tag
);
    logic [ADDR_W-1:0]  fetch_addr;
    logic [LEN_W-1:0]   fetch_rem;
    logic [CNT_W-1:0]   outstanding;
    logic [EPOCH_W-1:0] epoch;
    logic [CNT_W:0]     fill_sum;
    logic               credit_ok;
    logic               req_hs;

    // Free-space credit: buffered words plus words still on the way.
    always_comb begin
        fill_sum  = {1'b0, fifo_count} + {1'b0, outstanding};
        credit_ok = (fill_sum + (CNT_W + 1)'(BURST)) <= (CNT_W + 1)'(DEPTH);
    end

    assign req_len   = (fetch_rem < LEN_W'(BURST)) ? BL_W'(fetch_rem) : BL_W'(BURST);
    assign req_valid = (fetch_rem != '0) && credit_ok;
    assign req_addr  = fetch_addr;
    assign req_tag   = epoch;
    assign req_hs    = req_valid && req_ready;

    // Walk the fetch pointer, track words in flight, step the epoch on a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_addr  <= '0;
            fetch_rem   <= '0;
            outstanding <= '0;
            epoch       <= '0;
        end else if (load) begin
            fetch_addr  <= load_addr;
            fetch_rem   <= load_len;
            outstanding <= '0;
            epoch       <= epoch + 1'b1;
        end else begin
            if (req_hs) begin
                fetch_addr <= fetch_addr + ADDR_W'(req_len);
                fetch_rem  <= fetch_rem - LEN_W'(req_len);
            end
            outstanding <= outstanding + (req_hs ? CNT_W'(req_len) : '0)
                                       - (beat_take ? CNT_W'(1) : '0);
        end
    end

    // R3: buffered plus in-flight words never exceed FIFO capacity.
    p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_sum <= (CNT_W + 1)'(DEPTH));

    // R4: a request never asks for more than remains, nor for zero words.
    p_len_fit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len != '0) && (LEN_W'(req_len) <= fetch_rem));

    // R12: each load moves to the next epoch.
    p_epoch_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (epoch == $past(epoch) + 1'b1));
endmodule

// File: rtl/cmd_prefetch.sv
// Command stream prefetch front end: host start registers, read-ahead
// fetcher, prefetch FIFO, and jump/call/return redirect with a return stack.
// Assumes: the decoder issues at most one redirect per cycle; the host write
// takes priority over a redirect in the same cycle; memory returns beats in
// request order with the request tag echoed.
module cmd_prefetch #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int LEN_W       = 16,
    parameter int FIFO_DEPTH  = 16,
    parameter int BURST       = 4,
    parameter int STACK_DEPTH = 4,
    parameter int EPOCH_W     = 2,
    localparam int BL_W       = $clog2(BURST + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_sel,
    input  logic [ADDR_W-1:0]  host_wdata,
    output logic               rd_req_valid,
    input  logic               rd_req_ready,
    output logic [ADDR_W-1:0]  rd_req_addr,
    output logic [BL_W-1:0]    rd_req_len,
    output logic [EPOCH_W-1:0] rd_req_tag,
    output logic               rd_req_host,
    input  logic               rsp_valid,
    input  logic [EPOCH_W-1:0] rsp_tag,
    input  logic [DATA_W-1:0]  rsp_data,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [DATA_W-1:0]  cmd_data,
    input  logic               redir_valid,
    input  logic [1:0]         redir_kind,
    input  logic [ADDR_W-1:0]  redir_addr,
    input  logic [LEN_W-1:0]   redir_len,
    output logic               idle,
    output logic               seq_err
);
    import cbf_pkg::*;

    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
    localparam int ENT_W = ADDR_W + LEN_W;

    logic [LEN_W-1:0]  count_reg;
    logic [ADDR_W-1:0] cons_addr;
    logic [LEN_W-1:0]  cons_rem;
    logic              host_start, take, load;
    logic              is_call, is_ret;
    redir_kind_e       kind;
    logic [ADDR_W-1:0] ret_addr, load_addr;
    logic [LEN_W-1:0]  ret_rem, load_len;
    logic [ENT_W-1:0]  stk_top;
    logic              stk_full, stk_empty;
    logic              fifo_empty, beat_take;
    logic [CNT_W-1:0]  fifo_count;

    assign host_start = host_wr && (host_sel == HOST_SEL_START);
    assign take       = cmd_valid && cmd_ready;
    assign load       = host_start || redir_valid;
    assign kind       = redir_kind_e'(redir_kind);
    assign is_call    = redir_valid && !host_start && (kind == REDIR_CALL);
    assign is_ret     = redir_valid && !host_start && (kind == REDIR_RETURN);

    // Resume point: the word after any word taken in this same cycle.
    assign ret_addr = cons_addr + ADDR_W'(take);
    assign ret_rem  = cons_rem - LEN_W'(take);

    // Word-count register written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) count_reg <= '0;
        else if (host_wr && host_sel == HOST_SEL_COUNT) count_reg <= host_wdata[LEN_W-1:0];
    end

    // Pick the new stream position for a start or a redirect.
    always_comb begin
        if (host_start) begin
            load_addr = host_wdata;
            load_len  = count_reg;
        end else if (is_ret) begin
            load_addr = stk_empty ? cons_addr : stk_top[ENT_W-1:LEN_W];
            load_len  = stk_empty ? '0 : stk_top[LEN_W-1:0];
        end else begin
            load_addr = redir_addr;
            load_len  = redir_len;
        end
    end

    // Consumer-side position: next word owed to the decoder and words left.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cons_addr <= '0;
            cons_rem  <= '0;
        end else if (load) begin
            cons_addr <= load_addr;
            cons_rem  <= load_len;
        end else if (take) begin
            cons_addr <= cons_addr + 1'b1;
            cons_rem  <= cons_rem - 1'b1;
        end
    end

    // Sticky stack misuse flag, cleared by a new start.
    always_ff @(posedge clk) begin
        if (!rst_n || host_start) seq_err <= 1'b0;
        else if ((is_call && stk_full) || (is_ret && stk_empty)) seq_err <= 1'b1;
    end

    assign idle      = (cons_rem == '0);
    assign beat_take = rsp_valid && (rsp_tag == rd_req_tag) && !load;
    assign cmd_valid = !fifo_empty;
    assign rd_req_host = rd_req_addr[ADDR_W-1];

    cbf_req_gen #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEPTH(FIFO_DEPTH),
        .BURST(BURST), .EPOCH_W(EPOCH_W)
    ) u_req (
        .clk(clk), .rst_n(rst_n), .load(load), .load_addr(load_addr),
        .load_len(load_len), .fifo_count(fifo_count), .beat_take(beat_take),
        .req_ready(rd_req_ready), .req_valid(rd_req_valid), .req_addr(rd_req_addr),
        .req_len(rd_req_len), .req_tag(rd_req_tag)
    );

    cbf_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(load), .wr_en(beat_take),
        .wr_data(rsp_data), .rd_en(take), .rd_data(cmd_data),
        .empty(fifo_empty), .count(fifo_count)
    );

    cbf_ret_stack #(.ENT_W(ENT_W), .DEPTH(STACK_DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .clear(host_start), .push(is_call && !stk_full),
        .pop(is_ret && !stk_empty), .push_data({ret_addr, ret_rem}),
        .top_data(stk_top), .full(stk_full), .empty(stk_empty)
    );

    // R6: a redirect or start leaves nothing buffered for the decoder.
    p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !cmd_valid);

    // R6: a beat with a stale tag never adds to the FIFO.
    p_drop_stale_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_tag != rd_req_tag && !load) |=> (fifo_count <= $past(fifo_count)));

    // R10: the error flag holds until a new start.
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_err && !host_start) |=> seq_err);

    // R11: an idle block neither offers words nor requests memory.
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!cmd_valid && !rd_req_valid));
endmodule

// File: tb/sim_cmd_prefetch.sv
// Directed bench: one task per scenario, latency-configurable memory model,
// and a decoder model that takes words up to a limit set by each task.
module sim_cmd_prefetch;
    import cbf_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int LW = 16;
    localparam int BLW = 3;
    localparam int EW = 2;

    logic clk, rst_n;
    logic host_wr, host_sel;
    logic [AW-1:0] host_wdata;
    logic rd_req_valid, rd_req_ready, rd_req_host;
    logic [AW-1:0] rd_req_addr;
    logic [BLW-1:0] rd_req_len;
    logic [EW-1:0] rd_req_tag;
    logic rsp_valid;
    logic [EW-1:0] rsp_tag;
    logic [DW-1:0] rsp_data;
    logic cmd_valid, cmd_ready;
    logic [DW-1:0] cmd_data;
    logic redir_valid;
    logic [1:0] redir_kind;
    logic [AW-1:0] redir_addr;
    logic [LW-1:0] redir_len;
    logic idle, seq_err;

    cmd_prefetch u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_req_len(rd_req_len), .rd_req_tag(rd_req_tag),
        .rd_req_host(rd_req_host), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
        .rsp_data(rsp_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_data(cmd_data), .redir_valid(redir_valid), .redir_kind(redir_kind),
        .redir_addr(redir_addr), .redir_len(redir_len), .idle(idle), .seq_err(seq_err)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int cyc = 0;
    int mem_lat = 6;
    bit bp_en = 0;
    int rx_limit = 0;
    int beat_idx = 0;
    int host_bad = 0;
    int host_ones = 0;
    logic [DW-1:0] rx_q[$];
    logic [AW-1:0] mq_addr[$];
    int            mq_len[$];
    logic [EW-1:0] mq_tag[$];
    int            mq_due[$];
    int            lens_q[$];
    logic [AW-1:0] addr_log[$];
    logic [EW-1:0] tag_log[$];

    initial begin
        clk = 0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    // Memory and decoder models: decide at the falling edge what the next
    // rising edge will see.
    initial begin
        rd_req_ready = 0; rsp_valid = 0; rsp_data = '0; rsp_tag = '0; cmd_ready = 0;
        forever begin
            @(negedge clk);
            cyc++;
            rd_req_ready = !bp_en || (cyc % 5 != 3);
            if (rst_n && rd_req_valid && rd_req_ready) begin
                mq_addr.push_back(rd_req_addr);
                mq_len.push_back(int'(rd_req_len));
                mq_tag.push_back(rd_req_tag);
                mq_due.push_back(cyc + mem_lat);
                lens_q.push_back(int'(rd_req_len));
                addr_log.push_back(rd_req_addr);
                tag_log.push_back(rd_req_tag);
                if (rd_req_host != rd_req_addr[AW-1]) host_bad++;
                if (rd_req_host) host_ones++;
            end
            if (mq_addr.size() > 0 && cyc >= mq_due[0]) begin
                rsp_valid = 1;
                rsp_tag   = mq_tag[0];
                rsp_data  = {16'hC0DE, mq_addr[0] + 16'(beat_idx)};
                beat_idx++;
                if (beat_idx == mq_len[0]) begin
                    void'(mq_addr.pop_front()); void'(mq_len.pop_front());
                    void'(mq_tag.pop_front());  void'(mq_due.pop_front());
                    beat_idx = 0;
                end
            end else begin
                rsp_valid = 0;
            end
            cmd_ready = (rx_q.size() < rx_limit);
            if (rst_n && cmd_valid && cmd_ready) rx_q.push_back(cmd_data);
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic host_write(input logic sel, input logic [AW-1:0] d);
        host_wr = 1; host_sel = sel; host_wdata = d;
        tick(1);
        host_wr = 0;
    endtask

    task automatic start(input logic [AW-1:0] base, input logic [LW-1:0] len);
        rx_limit = 0;
        host_write(HOST_SEL_COUNT, len);
        host_write(HOST_SEL_START, base);
        rx_q.delete(); lens_q.delete(); addr_log.delete(); tag_log.delete();
        host_bad = 0; host_ones = 0;
    endtask

    task automatic redirect(input logic [1:0] k, input logic [AW-1:0] a, input logic [LW-1:0] l);
        redir_valid = 1; redir_kind = k; redir_addr = a; redir_len = l;
        tick(1);
        redir_valid = 0;
    endtask

    task automatic drain();
        int k = 0;
        while (mq_addr.size() != 0 && k < 2000) begin tick(1); k++; end
        tick(2);
    endtask

    task automatic wait_rx(input int n, input int max);
        int k = 0;
        while (rx_q.size() < n && k < max) begin tick(1); k++; end
    endtask

    // One check: rx_q[from .. from+n-1] must hold consecutive addresses from a0.
    task automatic check_seq(input int from, input logic [AW-1:0] a0, input int n, input string req);
        logic [31:0] act = '0;
        logic [31:0] exp = '0;
        bit ok = 1;
        for (int i = 0; i < n; i++) begin
            if (ok) begin
                exp = {16'hC0DE, a0 + 16'(i)};
                act = (rx_q.size() > from + i) ? rx_q[from + i] : 32'hDEAD_DEAD;
                if (act != exp) ok = 0;
            end
        end
        chk(ok, req, act, exp);
    endtask

    task automatic t_reset();
        chk(idle == 1'b1, "R1 idle", idle, 1);
        chk(cmd_valid == 1'b0, "R1 cmd_valid", cmd_valid, 0);
        chk(rd_req_valid == 1'b0, "R1 rd_req_valid", rd_req_valid, 0);
        chk(seq_err == 1'b0, "R1 seq_err", seq_err, 0);
    endtask

    task automatic t_linear();
        mem_lat = 6; bp_en = 1;
        start(16'h0100, 10);
        chk(idle == 1'b0, "R11 busy after start", idle, 0);
        rx_limit = 10;
        wait_rx(10, 600);
        tick(10);
        check_seq(0, 16'h0100, 10, "R2 linear order");
        chk(rx_q.size() == 10, "R2 word count", rx_q.size(), 10);
        chk(lens_q.size() == 3 && lens_q[0] == 4 && lens_q[1] == 4 && lens_q[2] == 2,
            "R4 burst lengths", (lens_q.size() == 3) ? lens_q[2] : lens_q.size(), 2);
        chk(addr_log.size() == 3 && addr_log[1] == 16'h0104 && addr_log[2] == 16'h0108,
            "R4 burst addresses", (addr_log.size() == 3) ? addr_log[2] : 0, 16'h0108);
        chk(host_ones == 0, "R5 local select", host_ones, 0);
        chk(idle == 1'b1, "R11 idle at end", idle, 1);
    endtask

    task automatic t_readahead();
        int sum = 0;
        bit all4 = 1;
        drain();
        mem_lat = 20; bp_en = 0;
        start(16'h0000, 64);
        tick(120);
        foreach (lens_q[i]) sum += lens_q[i];
        chk(sum == 16, "R3 read-ahead bound", sum, 16);
        chk(cmd_valid == 1'b1, "R3 buffered while stalled", cmd_valid, 1);
        chk(idle == 1'b0, "R11 not idle while stalled", idle, 0);
        rx_limit = 64;
        wait_rx(64, 3000);
        tick(5);
        check_seq(0, 16'h0000, 64, "R3 full stream order");
        foreach (lens_q[i]) if (lens_q[i] != 4) all4 = 0;
        chk(all4, "R4 full bursts", all4, 1);
    endtask

    task automatic t_hostbit();
        drain();
        mem_lat = 6; bp_en = 1;
        start(16'h8010, 5);
        rx_limit = 5;
        wait_rx(5, 600);
        tick(5);
        check_seq(0, 16'h8010, 5, "R5 host-mapped data");
        chk(host_bad == 0, "R5 select bit matches address", host_bad, 0);
        chk(host_ones == 2, "R5 host select on both bursts", host_ones, 2);
    endtask

    task automatic t_jump();
        logic [EW-1:0] t_old;
        int mark;
        drain();
        mem_lat = 12; bp_en = 0;
        start(16'h0200, 40);
        rx_limit = 5;
        wait_rx(5, 600);
        tick(3);
        t_old = tag_log[tag_log.size() - 1];
        redirect(REDIR_JUMP, 16'h0300, 6);
        mark = tag_log.size();
        rx_limit = 11;
        wait_rx(11, 800);
        tick(40);
        check_seq(0, 16'h0200, 5, "R6 words before jump");
        check_seq(5, 16'h0300, 6, "R6 words after jump");
        chk(rx_q.size() == 11, "R6 no stale words", rx_q.size(), 11);
        chk(idle == 1'b1, "R11 idle after jump target", idle, 1);
        chk(tag_log.size() > mark && tag_log[mark] == EW'(t_old + 1'b1), "R12 epoch step",
            (tag_log.size() > mark) ? tag_log[mark] : 0, EW'(t_old + 1'b1));
    endtask

    task automatic t_call();
        drain();
        mem_lat = 6; bp_en = 1;
        start(16'h0400, 8);
        rx_limit = 3;
        wait_rx(3, 600);
        tick(20);
        redirect(REDIR_CALL, 16'h0500, 4);
        rx_limit = 7;
        wait_rx(7, 600);
        tick(5);
        redirect(REDIR_RETURN, 16'h0000, 0);
        rx_limit = 12;
        wait_rx(12, 600);
        tick(20);
        check_seq(0, 16'h0400, 3, "R7 caller prefix");
        check_seq(3, 16'h0500, 4, "R7 callee body");
        check_seq(7, 16'h0403, 5, "R7 resume after return");
        chk(rx_q.size() == 12, "R7 total words", rx_q.size(), 12);
        chk(idle == 1'b1 && seq_err == 1'b0, "R7 clean finish", {idle, seq_err}, 2'b10);
    endtask

    task automatic t_overflow();
        drain();
        mem_lat = 6; bp_en = 0;
        start(16'h0600, 100);
        for (int i = 0; i < 4; i++) begin
            redirect(REDIR_CALL, 16'h0700 + 16'(i * 16), 8);
            tick(15);
        end
        chk(seq_err == 1'b0, "R8 four calls fit", seq_err, 0);
        redirect(REDIR_CALL, 16'h0740, 8);
        tick(2);
        chk(seq_err == 1'b1, "R8 overflow flagged", seq_err, 1);
        rx_limit = 1;
        wait_rx(1, 400);
        check_seq(0, 16'h0740, 1, "R8 overflowing call still jumps");
        tick(3);
        redirect(REDIR_RETURN, 16'h0000, 0);
        rx_limit = 2;
        wait_rx(2, 400);
        check_seq(1, 16'h0720, 1, "R8 last-in first-out return");
        tick(30);
        chk(seq_err == 1'b1, "R10 flag stays set", seq_err, 1);
    endtask

    task automatic t_underflow();
        drain();
        mem_lat = 6; bp_en = 0;
        start(16'h0800, 6);
        tick(2);
        chk(seq_err == 1'b0, "R10 start clears flag", seq_err, 1'b0);
        rx_limit = 2;
        wait_rx(2, 400);
        tick(3);
        redirect(REDIR_RETURN, 16'h0000, 0);
        tick(3);
        chk(seq_err == 1'b1, "R9 empty-stack return flagged (R10 stack cleared)", seq_err, 1);
        chk(idle == 1'b1, "R9 stream ends", idle, 1);
        rx_limit = 6;
        tick(40);
        chk(rx_q.size() == 2, "R9 no further words", rx_q.size(), 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; host_wr = 0; host_sel = 0; host_wdata = '0;
        redir_valid = 0; redir_kind = '0; redir_addr = '0; redir_len = '0;
        repeat (5) @(posedge clk);
        #1;
        rst_n = 1;
        tick(1);
        t_reset();
        t_linear();
        t_readahead();
        t_hostbit();
        t_jump();
        t_call();
        t_overflow();
        t_underflow();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule